// File: doc/BRIEF.md
# Flash Erase Command Sequence Interpreter

This block sits on the write side of a NOR-style flash bank model. It watches completed bus write cycles, each given as a one-cycle strobe with a word address and a data byte. It recognises the two six-write erase sequences. The first five writes are always the same: two unlock writes, the erase setup byte, and two more unlock writes. The sixth write decides the erase kind. A chip erase targets every sector at once. A sector erase names one sector through the upper address bits.

After a sector erase, the block does not start erasing straight away. It opens an acceptance window that lasts a parameterised number of clock cycles. Every further sector-erase write during the window adds its sector to a one-bit-per-sector buffer and restarts the window. An erase-suspend byte in the window is tolerated without effect. Any other write abandons the queued sectors and returns the bank to read mode. When the window runs out, a simulated erase runs for a separate parameterised number of cycles. During that time the ready output is low, the timer-expired status is high, and every write is ignored.

An asynchronous active-low reset ends an erase at once and returns the bank to read mode.

Top module: `erase_cmd_seq`

## Requirements
- R1: The write sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 starts a chip erase. The data values are hex bytes, and the addresses are hex values compared on the low 11 address bits. From the cycle after the final write, ready is low and erase_mask is all ones.
- R2: The same five leading writes followed by data 30 at any address open the acceptance window. The sector index is the top SECT_BITS bits of the address. Only that sector's bit is set in erase_mask, and ready stays high.
- R3: While the window is open, each write of data 30 sets the bit of the sector it addresses. Sectors may come in any order, a repeated sector is harmless, and the buffer can grow to every sector.
- R4: The window stays open for exactly WIN_CYC cycles after the most recent accepted sector write, since each such write restarts it. The erase then begins with erase_mask unchanged.
- R5: A write of data B0 during the window neither closes the window nor restarts its timing.
- R6: Any other write during the window closes it, clears erase_mask and returns to read mode, and no erase follows.
- R7: An erase keeps ready low for exactly ERASE_CYC cycles. Writes during that time change neither erase_mask nor the duration, and they leave no partial sequence behind.
- R8: When an erase ends, ready returns high with erase_mask cleared, and a new sequence is accepted at once.
- R9: A write whose address or data does not match the next expected step returns the decoder to read mode, so the broken sequence starts no erase. Cycles without a write between sequence steps have no effect.
- R10: Asserting rst_n low immediately forces ready high, win_open low, timer_expired low and erase_mask to zero, even mid-erase. After release, sequences work again.
- R11: timer_expired is low in read mode and while the window is open, and it is high for the whole of an erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously inside |
| wr_en | input | 1 | One-cycle strobe marking a completed bus write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Data byte of the write |
| ready | output | 1 | High when no erase is running |
| win_open | output | 1 | High while the sector acceptance window is open |
| timer_expired | output | 1 | High once the acceptance window has closed and an erase runs |
| erase_mask | output | 2**SECT_BITS | One bit per sector queued or being erased |

## Verification
The main function is swept over every non-empty subset of the eight sectors of a small configuration. The first sector is named in the sequence, the rest follow in descending order, and the first is written again. This separates the per-sector set logic from the order and duplicate handling, and it also checks the exact window and erase lengths. Each step of the chip-erase sequence is corrupted in turn, once in data and once in address, to show that every step compares both. Injected writes inside the window are placed at a known offset: a sector byte, the suspend byte and a foreign byte. They separate retrigger, tolerate and abort, because the measured window length differs in each case.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam int UNLK_W = 11;
  localparam logic [UNLK_W-1:0] ADDR_KEY_A = 11'h555;
  localparam logic [UNLK_W-1:0] ADDR_KEY_B = 11'h2AA;

  localparam logic [7:0] DAT_KEY_A   = 8'hAA;
  localparam logic [7:0] DAT_KEY_B   = 8'h55;
  localparam logic [7:0] DAT_SETUP   = 8'h80;
  localparam logic [7:0] DAT_CHIP    = 8'h10;
  localparam logic [7:0] DAT_SECTOR  = 8'h30;
  localparam logic [7:0] DAT_SUSPEND = 8'hB0;

  typedef enum logic [2:0] {
    ST_READ,
    ST_KEY1,
    ST_KEY2,
    ST_ARMED,
    ST_KEY3,
    ST_KEY4,
    ST_WINDOW,
    ST_ERASE
  } seq_state_e;

  typedef struct packed {
    logic key_a;
    logic key_b;
    logic setup;
    logic chip;
    logic sector;
    logic suspend;
  } cmd_class_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int SECT_BITS = 7
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           data,
  output cmd_class_t           cls,
  output logic [SECT_BITS-1:0] sect
);

  logic [UNLK_W-1:0] lo;
  logic              unused_addr_bits;

  assign lo               = addr[UNLK_W-1:0];
  assign unused_addr_bits = ^addr;

  always_comb begin
    cls.key_a   = (lo == ADDR_KEY_A) && (data == DAT_KEY_A);
    cls.key_b   = (lo == ADDR_KEY_B) && (data == DAT_KEY_B);
    cls.setup   = (lo == ADDR_KEY_A) && (data == DAT_SETUP);
    cls.chip    = (lo == ADDR_KEY_A) && (data == DAT_CHIP);
    cls.sector  = (data == DAT_SECTOR);
    cls.suspend = (data == DAT_SUSPEND);
  end

  assign sect = addr[ADDR_W-1 -: SECT_BITS];

endmodule

// File: rtl/down_timer.sv
module down_timer #(
  parameter int LOAD = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);

  localparam int W = (LOAD < 2) ? 1 : $clog2(LOAD + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = W'(LOAD - 1);
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sector_buf.sv
module sector_buf #(
  parameter int SECT_BITS = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      set_all,
  input  logic                      set_one,
  input  logic [SECT_BITS-1:0]      idx,
  output logic [(1<<SECT_BITS)-1:0] mask
);

  localparam int NUM_SECT = 1 << SECT_BITS;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    logic bit_d;

    always_comb begin
      bit_d = mask[i];
      if (clr)
        bit_d = 1'b0;
      else if (set_all)
        bit_d = 1'b1;
      else if (set_one && (idx == SECT_BITS'(i)))
        bit_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask[i] <= 1'b0;
      else        mask[i] <= bit_d;
    end
  end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import erase_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  cmd_class_t cls,
  input  logic       win_zero,
  input  logic       ers_zero,
  output logic       win_load,
  output logic       win_run,
  output logic       ers_load,
  output logic       ers_run,
  output logic       buf_clr,
  output logic       buf_all,
  output logic       buf_set,
  output logic       ready,
  output logic       win_open,
  output logic       expired
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_READ:   if (wr_en) st_d = cls.key_a ? ST_KEY1  : ST_READ;
      ST_KEY1:   if (wr_en) st_d = cls.key_b ? ST_KEY2  : ST_READ;
      ST_KEY2:   if (wr_en) st_d = cls.setup ? ST_ARMED : ST_READ;
      ST_ARMED:  if (wr_en) st_d = cls.key_a ? ST_KEY3  : ST_READ;
      ST_KEY3:   if (wr_en) st_d = cls.key_b ? ST_KEY4  : ST_READ;
      ST_KEY4: begin
        if (wr_en) begin
          if (cls.chip)        st_d = ST_ERASE;
          else if (cls.sector) st_d = ST_WINDOW;
          else                 st_d = ST_READ;
        end
      end
      ST_WINDOW: begin
        if (wr_en && cls.sector)       st_d = ST_WINDOW;
        else if (wr_en && !cls.suspend) st_d = ST_READ;
        else if (win_zero)             st_d = ST_ERASE;
      end
      ST_ERASE:  if (ers_zero) st_d = ST_READ;
      default:   st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_READ;
    else        st_q <= st_d;
  end

  logic sect_take;
  assign sect_take = wr_en && cls.sector &&
                     ((st_q == ST_KEY4) || (st_q == ST_WINDOW));

  assign win_load = sect_take;
  assign win_run  = (st_q == ST_WINDOW);
  assign ers_load = (st_q != ST_ERASE) && (st_d == ST_ERASE);
  assign ers_run  = (st_q == ST_ERASE);
  assign buf_clr  = (st_d == ST_READ);
  assign buf_all  = wr_en && cls.chip && (st_q == ST_KEY4);
  assign buf_set  = sect_take;

  assign ready    = (st_q != ST_ERASE);
  assign win_open = (st_q == ST_WINDOW);
  assign expired  = (st_q == ST_ERASE);

endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int SECT_BITS = 7,
  parameter int WIN_CYC   = 4000,
  parameter int ERASE_CYC = 100000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  output logic                      ready,
  output logic                      win_open,
  output logic                      timer_expired,
  output logic [(1<<SECT_BITS)-1:0] erase_mask
);

  localparam int NUM_SECT = 1 << SECT_BITS;

  logic [1:0] rst_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  cmd_class_t           cls;
  logic [SECT_BITS-1:0] sect;
  logic win_load, win_run, win_zero;
  logic ers_load, ers_run, ers_zero;
  logic buf_clr, buf_all, buf_set;

  cmd_decode #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_dec (
    .addr (wr_addr),
    .data (wr_data),
    .cls  (cls),
    .sect (sect)
  );

  seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_i),
    .wr_en    (wr_en),
    .cls      (cls),
    .win_zero (win_zero),
    .ers_zero (ers_zero),
    .win_load (win_load),
    .win_run  (win_run),
    .ers_load (ers_load),
    .ers_run  (ers_run),
    .buf_clr  (buf_clr),
    .buf_all  (buf_all),
    .buf_set  (buf_set),
    .ready    (ready),
    .win_open (win_open),
    .expired  (timer_expired)
  );

  down_timer #(.LOAD(WIN_CYC)) u_win_tmr (
    .clk   (clk),
    .rst_n (rst_i),
    .load  (win_load),
    .run   (win_run),
    .zero  (win_zero)
  );

  down_timer #(.LOAD(ERASE_CYC)) u_ers_tmr (
    .clk   (clk),
    .rst_n (rst_i),
    .load  (ers_load),
    .run   (ers_run),
    .zero  (ers_zero)
  );

  logic [NUM_SECT-1:0] mask;

  sector_buf #(.SECT_BITS(SECT_BITS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (buf_clr),
    .set_all (buf_all),
    .set_one (buf_set),
    .idx     (sect),
    .mask    (mask)
  );

  assign erase_mask = mask;

endmodule

// File: rtl/erase_cmd_seq_chk.sv
module erase_cmd_seq_chk #(
  parameter int SECT_BITS = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ready,
  input logic                      win_open,
  input logic                      timer_expired,
  input logic [(1<<SECT_BITS)-1:0] erase_mask
);

  // R1: an erase always has at least one target sector
  a_r1_busy_has_target: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (erase_mask != '0));

  // R3: sectors only accumulate while the window stays open
  a_r3_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && $past(win_open)) |->
      ((erase_mask & $past(erase_mask)) == $past(erase_mask)));

  // R4 and R6: the window closes into an erase or into a cleared read mode
  a_r4_window_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win_open) && !win_open) |-> (!ready || (erase_mask == '0)));

  // R7: targets stay frozen through an erase
  a_r7_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(erase_mask));

  // R8: read mode holds no queued sectors
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !win_open) |-> (erase_mask == '0));

  // R11: expiry status never shows while the window is open
  a_r11_expired_low_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> !timer_expired);

endmodule

bind erase_cmd_seq erase_cmd_seq_chk #(.SECT_BITS(SECT_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ready         (ready),
  .win_open      (win_open),
  .timer_expired (timer_expired),
  .erase_mask    (erase_mask)
);

// File: tb/tb_erase_cmd_seq.sv
module tb_erase_cmd_seq;

  localparam int AW = 12;
  localparam int SB = 3;
  localparam int NS = 1 << SB;
  localparam int WC = 20;
  localparam int EC = 30;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          ready, win_open, timer_expired;
  logic [NS-1:0] erase_mask;

  int total = 0;
  int bad   = 0;

  localparam logic [AW-1:0] SA [6] = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h555};
  localparam logic [7:0]    SD [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};

  erase_cmd_seq #(.ADDR_W(AW), .SECT_BITS(SB), .WIN_CYC(WC), .ERASE_CYC(EC)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ready         (ready),
    .win_open      (win_open),
    .timer_expired (timer_expired),
    .erase_mask    (erase_mask)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] sect_addr(input int s);
    return {s[SB-1:0], 9'h0F3};
  endfunction

  task automatic lead_in();
    for (int i = 0; i < 5; i++) wr(SA[i], SD[i]);
  endtask

  task automatic measure_window(input int inj, input logic [AW-1:0] a,
                                input logic [7:0] d, output int n);
    n = 0;
    while (win_open && n < 1000) begin
      n++;
      if (n == inj) begin
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, first;
    logic [NS-1:0] m;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R10 / R11: reset state
    check("R10 reset ready", ready, 1);
    check("R10 reset win_open", win_open, 0);
    check("R11 reset timer_expired", timer_expired, 0);
    check("R10 reset mask", erase_mask, 0);

    // R1: chip erase
    for (int i = 0; i < 6; i++) wr(SA[i], SD[i]);
    check("R1 chip busy", ready, 0);
    check("R1 chip mask", erase_mask, (1 << NS) - 1);
    check("R11 chip expired", timer_expired, 1);
    measure_busy(n);
    check("R7 chip busy length", n, EC);
    check("R8 chip done mask", erase_mask, 0);

    // R2 R3 R4 R7 R8: sweep every non-empty sector subset
    for (int mi = 1; mi < (1 << NS); mi++) begin
      m = mi[NS-1:0];
      first = 0;
      for (int b = NS - 1; b >= 0; b--) if (m[b]) first = b;
      lead_in();
      wr(sect_addr(first), 8'h30);
      check("R2 window open", win_open, 1);
      check("R2 single bit", erase_mask, 1 << first);
      check("R2 ready during window", ready, 1);
      for (int b = NS - 1; b >= 0; b--)
        if (m[b] && b != first) wr(sect_addr(b), 8'h30);
      wr(sect_addr(first), 8'h30);
      check("R3 accumulated mask", erase_mask, m);
      measure_window(-1, '0, '0, n);
      check("R4 window length", n, WC);
      check("R4 mask at erase start", erase_mask, m);
      check("R11 expired during erase", timer_expired, 1);
      measure_busy(n);
      check("R7 erase length", n, EC);
      check("R8 mask cleared", erase_mask, 0);
    end

    // R4: retrigger at offset 10 extends the window
    lead_in();
    wr(sect_addr(1), 8'h30);
    measure_window(10, sect_addr(6), 8'h30, n);
    check("R4 retrigger length", n, 10 + WC);
    check("R4 retrigger mask", erase_mask, 8'h42);
    measure_busy(n);

    // R5: suspend byte neither aborts nor retriggers
    lead_in();
    wr(sect_addr(3), 8'h30);
    measure_window(5, 12'h123, 8'hB0, n);
    check("R5 suspend window length", n, WC);
    check("R5 erase follows", ready, 0);
    check("R5 mask kept", erase_mask, 8'h08);
    measure_busy(n);

    // R6: foreign write aborts the window
    lead_in();
    wr(sect_addr(2), 8'h30);
    wr(sect_addr(4), 8'h30);
    idle(4);
    wr(12'h555, 8'hF0);
    check("R6 window closed", win_open, 0);
    check("R6 mask cleared", erase_mask, 0);
    idle(WC + 5);
    check("R6 no erase", ready, 1);
    check("R11 expired low after abort", timer_expired, 0);

    // R7: writes during erase ignored
    for (int i = 0; i < 6; i++) wr(SA[i], SD[i]);
    n = ready ? 0 : 1;
    for (int i = 0; i < 6; i++) begin
      wr(SA[i], SD[i]);
      if (!ready) n++;
      check("R7 mask frozen", erase_mask, (1 << NS) - 1);
    end
    begin
      int rest;
      measure_busy(rest);
      check("R7 duration unaffected", n + rest - 1, EC);
    end
    idle(3);
    check("R7 no sequence left", ready, 1);
    check("R7 no window left", win_open, 0);

    // R8: new sequence right after completion
    wr(SA[0], SD[0]);
    for (int i = 1; i < 5; i++) wr(SA[i], SD[i]);
    wr(sect_addr(7), 8'h30);
    check("R8 immediate reuse", erase_mask, 8'h80);
    measure_window(-1, '0, '0, n);
    measure_busy(n);

    // R9: corrupt each step in data then in address
    for (int pos = 0; pos < 6; pos++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int i = 0; i < 6; i++) begin
          if (i == pos && kind == 0)      wr(SA[i], SD[i] ^ 8'h01);
          else if (i == pos)              wr(SA[i] ^ 12'h001, SD[i]);
          else                            wr(SA[i], SD[i]);
        end
        idle(2);
        check("R9 broken sequence ready", ready, 1);
        check("R9 broken sequence mask", erase_mask, 0);
      end
    end

    // R9: idle cycles between steps are harmless
    for (int i = 0; i < 6; i++) begin
      idle(3);
      wr(SA[i], SD[i]);
    end
    check("R9 gaps chip erase", ready, 0);
    measure_busy(n);
    check("R9 gaps erase length", n, EC);

    // R10: reset mid-erase
    for (int i = 0; i < 6; i++) wr(SA[i], SD[i]);
    idle(5);
    rst_n = 1'b0;
    #1;
    check("R10 reset ready", ready, 1);
    check("R10 reset mask", erase_mask, 0);
    check("R10 reset expired", timer_expired, 0);
    @(negedge clk);
    idle(1);
    rst_n = 1'b1;
    idle(3);
    lead_in();
    wr(sect_addr(5), 8'h30);
    check("R10 after release window", win_open, 1);
    check("R10 after release mask", erase_mask, 8'h20);
    measure_window(-1, '0, '0, n);
    measure_busy(n);
    check("R10 after release erase length", n, EC);

    finish_run();
  end

endmodule